// File: doc/BRIEF.md
# Crystal Time Base and Reference Generator

This block turns one crystal-rate clock, nominally 7.2 MHz, into three timing outputs for a tuner synthesizer. The first is a selectable phase-comparison reference, picked by a 3-bit code from seven rates between 1 kHz and 100 kHz. The second is a fixed 400 kHz clock for a companion controller. The third is a slow 8 Hz time-base signal. Each output comes in two forms: a single-cycle enable pulse in the crystal clock domain and a square wave. Other logic on the same clock can use the pulses as enables. The square waves can drive pins.

All dividers are counters that run on the crystal clock. The reference divider reloads its period from the code. When the code changes, it restarts its count at once, so a period from the old setting is never mixed with one from the new setting. The controller clock and the time base share one cascade of three counters. The first counter sets the controller period, and the two after it divide further down to the time base.

Top module: `tbase_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, all three pulse outputs are low and all three square outputs are high.
- R2: The reference divide ratio is CLK_KHZ divided by the rate that the select code chooses: 000 gives 100 kHz (72), 001 gives 50 kHz (144), 010 gives 25 kHz (288), 011 gives 5 kHz (1440), 100 gives 10 kHz (720), 101 gives 9 kHz (800), 110 gives 1 kHz (7200) and 111 gives 5 kHz (1440). The numbers in brackets are the cycle counts at the default 7.2 MHz.
- R3: The reference pulse is one cycle wide, and with a steady code it repeats exactly every divide-ratio cycles.
- R4: Within each reference period, the reference square output is high for the first floor(ratio/2) cycles and low for the rest.
- R5: When the select code changes, no reference pulse is produced in the cycle where the new code first appears. The counter restarts, and the first pulse at the new rate comes in the ratio-th cycle after the change.
- R6: The controller pulse repeats every CTL_DIV cycles (18 by default, which is 400 kHz). Its square output is high for floor(CTL_DIV/2) of those cycles.
- R7: The time-base pulse repeats every CTL_DIV*TB_DIV1*TB_DIV2 cycles (900000 by default, which is 8 Hz).
- R8: The time-base square output is high for floor(TB_DIV2/2)*TB_DIV1*CTL_DIV cycles of each time-base period.
- R9: Every time-base pulse falls in a cycle that also carries a controller pulse, and both outputs then begin a new period together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Crystal-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_sel_i | input | 3 | Reference rate select code |
| ref_tick_o | output | 1 | Reference enable pulse |
| ref_sq_o | output | 1 | Reference square wave |
| ctl_tick_o | output | 1 | Controller clock enable pulse |
| ctl_sq_o | output | 1 | Controller clock square wave |
| tb_tick_o | output | 1 | Time-base enable pulse |
| tb_sq_o | output | 1 | Time-base square wave |

## Verification
The time-base pulse and the controller pulse can fall in the same cycle, because the last cascade stage can only wrap when the first stage wraps. The bench shortens the two later stages through parameters so that several time-base periods fit in the run. At every time-base pulse it checks that the controller pulse is high in that same sampled cycle, and that the next controller period again measures CTL_DIV. A second collision is set up on purpose: the select code is changed in exactly the cycle that carries a reference pulse, and the check is that the pulse disappears and the next one arrives a full new period later.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

    typedef logic [2:0] rate_sel_t;

    // Reference rate in kHz chosen by the select code.
    function automatic int unsigned rate_khz(input rate_sel_t code);
        case (code)
            3'd0:    rate_khz = 100;
            3'd1:    rate_khz = 50;
            3'd2:    rate_khz = 25;
            3'd3:    rate_khz = 5;
            3'd4:    rate_khz = 10;
            3'd5:    rate_khz = 9;
            3'd6:    rate_khz = 1;
            default: rate_khz = 5;
        endcase
    endfunction

    // Divide ratio for a code at a given input clock rate in kHz.
    function automatic int unsigned ref_ratio(input rate_sel_t code, input int unsigned clk_khz);
        ref_ratio = clk_khz / rate_khz(code);
    endfunction

endpackage

// File: rtl/tbase_ref_div.sv
module tbase_ref_div
    import tbase_pkg::*;
#(
    parameter int unsigned CLK_KHZ = 7200
) (
    input  logic      clk_i,
    input  logic      rst_ni,
    input  rate_sel_t sel_i,
    output logic      tick_o,
    output logic      sq_o
);

    // Widest period is the 1 kHz setting.
    localparam int unsigned MAX_RATIO = CLK_KHZ;
    localparam int unsigned CNT_W     = $clog2(MAX_RATIO);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        rate_sel_t        code;
    } ref_state_t;

    ref_state_t       st_d, st_q;
    logic [CNT_W-1:0] ratio_q;
    logic [CNT_W-1:0] last_q;
    logic             code_same;

    always_comb begin
        ratio_q   = CNT_W'(ref_ratio(st_q.code, CLK_KHZ));
        last_q    = ratio_q - 1'b1;
        code_same = (sel_i == st_q.code);
        st_d      = st_q;
        if (!code_same) begin
            st_d.code = sel_i;
            st_d.cnt  = '0;
        end else if (st_q.cnt == last_q) begin
            st_d.cnt  = '0;
        end else begin
            st_d.cnt  = st_q.cnt + 1'b1;
        end
        tick_o = code_same && (st_q.cnt == last_q);
        sq_o   = (st_q.cnt < (ratio_q >> 1));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R5: a new code restarts the count on the next edge
    p_restart_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i != st_q.code) |=> (st_q.cnt == '0 && st_q.code == $past(sel_i)));

    // R3: counter never leaves the period of the active code
    p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cnt < ratio_q);

endmodule

// File: rtl/tbase_chain.sv
module tbase_chain #(
    parameter int unsigned CTL_DIV = 18,
    parameter int unsigned TB_DIV1 = 1000,
    parameter int unsigned TB_DIV2 = 50
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic ctl_tick_o,
    output logic ctl_sq_o,
    output logic tb_tick_o,
    output logic tb_sq_o
);

    localparam int unsigned W0 = $clog2(CTL_DIV);
    localparam int unsigned W1 = $clog2(TB_DIV1);
    localparam int unsigned W2 = $clog2(TB_DIV2);
    localparam logic [W0-1:0] LAST0 = W0'(CTL_DIV - 1);
    localparam logic [W1-1:0] LAST1 = W1'(TB_DIV1 - 1);
    localparam logic [W2-1:0] LAST2 = W2'(TB_DIV2 - 1);
    localparam logic [W0-1:0] HALF0 = W0'(CTL_DIV / 2);
    localparam logic [W2-1:0] HALF2 = W2'(TB_DIV2 / 2);

    typedef struct packed {
        logic [W0-1:0] cnt0;
        logic [W1-1:0] cnt1;
        logic [W2-1:0] cnt2;
    } chain_state_t;

    chain_state_t st_d, st_q;
    logic         wrap0, wrap1, wrap2;

    always_comb begin
        wrap0 = (st_q.cnt0 == LAST0);
        wrap1 = wrap0 && (st_q.cnt1 == LAST1);
        wrap2 = wrap1 && (st_q.cnt2 == LAST2);
        st_d  = st_q;
        st_d.cnt0 = wrap0 ? '0 : st_q.cnt0 + 1'b1;
        if (wrap0) begin
            st_d.cnt1 = (st_q.cnt1 == LAST1) ? '0 : st_q.cnt1 + 1'b1;
        end
        if (wrap1) begin
            st_d.cnt2 = (st_q.cnt2 == LAST2) ? '0 : st_q.cnt2 + 1'b1;
        end
        ctl_tick_o = wrap0;
        ctl_sq_o   = (st_q.cnt0 < HALF0);
        tb_tick_o  = wrap2;
        tb_sq_o    = (st_q.cnt2 < HALF2);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R6: a controller pulse starts a fresh controller period
    p_ctl_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctl_tick_o |=> (st_q.cnt0 == '0));

    // R9: time-base pulse leaves the whole cascade at zero
    p_tb_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tb_tick_o |=> (st_q.cnt0 == '0 && st_q.cnt1 == '0 && st_q.cnt2 == '0));

    // R7: later stages stay within their ratios
    p_stage_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.cnt1 <= LAST1) && (st_q.cnt2 <= LAST2));

endmodule

// File: rtl/tbase_gen.sv
module tbase_gen
    import tbase_pkg::*;
#(
    parameter int unsigned CLK_KHZ = 7200,
    parameter int unsigned CTL_DIV = 18,
    parameter int unsigned TB_DIV1 = 1000,
    parameter int unsigned TB_DIV2 = 50
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [2:0] ref_sel_i,
    output logic       ref_tick_o,
    output logic       ref_sq_o,
    output logic       ctl_tick_o,
    output logic       ctl_sq_o,
    output logic       tb_tick_o,
    output logic       tb_sq_o
);

    tbase_ref_div #(
        .CLK_KHZ (CLK_KHZ)
    ) i_ref_div (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .sel_i  (rate_sel_t'(ref_sel_i)),
        .tick_o (ref_tick_o),
        .sq_o   (ref_sq_o)
    );

    tbase_chain #(
        .CTL_DIV (CTL_DIV),
        .TB_DIV1 (TB_DIV1),
        .TB_DIV2 (TB_DIV2)
    ) i_chain (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .ctl_tick_o (ctl_tick_o),
        .ctl_sq_o   (ctl_sq_o),
        .tb_tick_o  (tb_tick_o),
        .tb_sq_o    (tb_sq_o)
    );

    // R3: reference pulse is a single cycle wide
    p_ref_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ref_tick_o |=> !ref_tick_o);

endmodule

// File: tb/test_tbase_gen.sv
module test_tbase_gen;

    localparam int CLK_PERIOD = 10;
    localparam int CLK_KHZ    = 7200;
    localparam int CTL_DIV    = 18;
    localparam int TB_DIV1    = 20;
    localparam int TB_DIV2    = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] ref_sel = 3'd0;
    logic       ref_tick, ref_sq, ctl_tick, ctl_sq, tb_tick, tb_sq;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tbase_gen #(
        .CLK_KHZ (CLK_KHZ),
        .CTL_DIV (CTL_DIV),
        .TB_DIV1 (TB_DIV1),
        .TB_DIV2 (TB_DIV2)
    ) i_tbase_gen (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .ref_sel_i  (ref_sel),
        .ref_tick_o (ref_tick),
        .ref_sq_o   (ref_sq),
        .ctl_tick_o (ctl_tick),
        .ctl_sq_o   (ctl_sq),
        .tb_tick_o  (tb_tick),
        .tb_sq_o    (tb_sq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_ratio(input int code);
        int khz;
        case (code)
            0: khz = 100;
            1: khz = 50;
            2: khz = 25;
            3: khz = 5;
            4: khz = 10;
            5: khz = 9;
            6: khz = 1;
            default: khz = 5;
        endcase
        return CLK_KHZ / khz;
    endfunction

    function automatic logic pick_tick(input int which);
        case (which)
            0: return ref_tick;
            1: return ctl_tick;
            default: return tb_tick;
        endcase
    endfunction

    function automatic logic pick_sq(input int which);
        case (which)
            0: return ref_sq;
            1: return ctl_sq;
            default: return tb_sq;
        endcase
    endfunction

    // Sync to a pulse, then count cycles and square-high cycles up to the next pulse.
    task automatic measure(input int which, output int per, output int hi);
        per = 0;
        hi  = 0;
        do @(negedge clk); while (!pick_tick(which));
        do begin
            @(negedge clk);
            per++;
            if (pick_sq(which)) hi++;
        end while (!pick_tick(which));
    endtask

    task automatic t_reset;
        rst_n   = 1'b0;
        ref_sel = 3'd0;
        repeat (3) @(negedge clk);
        check(!ref_tick && !ctl_tick && !tb_tick, "R1 pulses in reset", {ref_tick, ctl_tick, tb_tick}, 0);
        check(ref_sq && ctl_sq && tb_sq, "R1 squares in reset", {ref_sq, ctl_sq, tb_sq}, 7);
        rst_n = 1'b1;
        @(negedge clk);
        check(!ref_tick && !ctl_tick && !tb_tick, "R1 pulses after release", {ref_tick, ctl_tick, tb_tick}, 0);
        check(ref_sq && ctl_sq && tb_sq, "R1 squares after release", {ref_sq, ctl_sq, tb_sq}, 7);
    endtask

    task automatic t_codes;
        int per, hi;
        for (int code = 0; code < 8; code++) begin
            @(negedge clk);
            ref_sel = 3'(code);
            measure(0, per, hi);
            check(per == exp_ratio(code), $sformatf("R2 ratio code %0d", code), per, exp_ratio(code));
            check(hi == exp_ratio(code) / 2, $sformatf("R4 high time code %0d", code), hi, exp_ratio(code) / 2);
        end
    endtask

    task automatic t_single;
        int per, hi;
        @(negedge clk);
        ref_sel = 3'd0;
        measure(0, per, hi);
        check(per == 72, "R3 steady period", per, 72);
        @(negedge clk);
        check(!ref_tick, "R3 pulse width", ref_tick, 0);
    endtask

    task automatic t_restart;
        int n;
        @(negedge clk);
        ref_sel = 3'd0;
        do @(negedge clk); while (!ref_tick);
        ref_sel = 3'd4;
        #1;
        check(!ref_tick, "R5 pulse dropped on change", ref_tick, 0);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!ref_tick);
        check(n == 720, "R5 first period after change", n, 720);
        repeat (100) @(negedge clk);
        ref_sel = 3'd0;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!ref_tick);
        check(n == 72, "R5 mid-period restart", n, 72);
    endtask

    task automatic t_ctl;
        int per, hi;
        for (int k = 0; k < 3; k++) begin
            measure(1, per, hi);
            check(per == CTL_DIV, "R6 controller period", per, CTL_DIV);
            check(hi == CTL_DIV / 2, "R6 controller high time", hi, CTL_DIV / 2);
        end
    endtask

    task automatic t_tb;
        int per, hi, cper, chi;
        int exp_per = CTL_DIV * TB_DIV1 * TB_DIV2;
        int exp_hi  = (TB_DIV2 / 2) * TB_DIV1 * CTL_DIV;
        for (int k = 0; k < 2; k++) begin
            measure(2, per, hi);
            check(per == exp_per, "R7 time-base period", per, exp_per);
            check(hi == exp_hi, "R8 time-base high time", hi, exp_hi);
            check(ctl_tick, "R9 controller pulse with time-base pulse", ctl_tick, 1);
            cper = 0;
            chi  = 0;
            do begin
                @(negedge clk);
                cper++;
                if (ctl_sq) chi++;
            end while (!ctl_tick);
            check(cper == CTL_DIV, "R9 controller period after time-base pulse", cper, CTL_DIV);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_codes();
        t_single();
        t_restart();
        t_ctl();
        t_tb();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule